// File: doc/BRIEF.md
# Programmable prescaled down-counter timer

This block is a single countdown timer that sits behind a simple word-addressed register port. Software programs a limit value and a control byte. The count then decrements on qualified ticks and raises a level interrupt each time the count expires. A tick is a cycle in which the clock-enable input `tickEn` is high, after an optional prescaler that divides by 1, 16 or 256.

The count runs in one of three modes. In free-running mode it wraps through the full 16-bit or 32-bit range and ignores the programmed limit. In periodic mode it restarts from the limit after reaching zero. In one-shot mode it stops at zero. The limit can be written in two ways: one write restarts the count at once, the other only stages a value for the next natural reload. Raw and masked interrupt status can be read back, and a write-only location clears the interrupt.

Top module: `down_timer`

## Requirements
- R1: After reset, the control byte reads 0x20 (interrupt enable only), and the limit, current count, raw status and masked status all read 0. `irqOut` is low.
- R2: The prescale field is control bits [3:2]. Code 0 divides the ticks by 1, code 1 by 16, code 2 by 256, and code 3 by 1. The prescaler advances only while the timer is enabled and restarts from zero on every write to the control word.
- R3: The control word is at word offset 2, and its eight low bits read back as written. The fields are: bit 0 one-shot, bit 1 32-bit width, bits [3:2] prescale, bit 5 interrupt enable, bit 6 periodic, bit 7 run enable. One-shot takes precedence over periodic.
- R4: With bits 0 and 6 both clear (free-running), a count at zero reloads to 0xFFFF in 16-bit mode or to 0xFFFFFFFF in 32-bit mode. A write to offset 0 also loads this maximum, whatever the written limit.
- R5: In periodic mode (bit 6 set, bit 0 clear), the count decrements once per prescaled tick. On the tick after it reaches zero it reloads the limit, so the period is limit+1 ticks.
- R6: In one-shot mode the count stops at zero and stays there until offset 0 is written again.
- R7: The raw flag (read at offset 4, bit 0) sets on the tick that takes the count from 1 to 0. A write of any value to offset 3 clears it. If both happen in the same cycle, the set wins.
- R8: The masked status at offset 5 and `irqOut` both equal the raw flag ANDed with control bit 5.
- R9: A write to offset 0 stores the limit and reloads the count on the next clock edge. A write to offset 6 stores only the limit, which is used at the next reload.
- R10: In 16-bit mode (bit 1 clear), only the low 16 bits of the count and of the loaded value are used, and bits [31:16] of the count read as zero. The stored limit keeps all 32 bits.
- R11: Offsets 0 and 6 both read the stored limit, and offset 1 reads the current count. `rdData` updates on the clock edge that samples `rdEn` and holds otherwise.
- R12: Writes to offset 1 and to unmapped offsets (7 and above) change nothing. Reads of offset 3 and of unmapped offsets return zero.
- R13: While bit 7 is clear, ticks leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count qualifier; one pulse is one tick before prescaling |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W (4) | Word offset |
| wrData | input | DATA_W (32) | Write data |
| rdData | output | DATA_W (32) | Registered read data |
| irqOut | output | 1 | Level interrupt, raw flag gated by enable |

## Verification
The embedded properties assume that a write to offset 0 never falls in the same cycle as a prescaled tick, because the reload would take priority over the decrement. They also assume that a control write is the only thing that changes the prescale field. The stimulus holds `tickEn` low during every register access, so loads, clears and control changes never meet a count step. Register ticks are issued only as runs of `tickEn` between accesses. The sweeps cover limits 0 to 5 in periodic mode against elapsed tick counts, a one-shot run past zero, all four prescale codes and a full 16-bit wrap. Every expected count is computed with modular arithmetic in the bench.

// File: rtl/down_timer_pkg.sv
package down_timer_pkg;

  // word offsets of the register port
  localparam int unsigned OFF_LOAD  = 0;
  localparam int unsigned OFF_VALUE = 1;
  localparam int unsigned OFF_CTRL  = 2;
  localparam int unsigned OFF_CLR   = 3;
  localparam int unsigned OFF_RAW   = 4;
  localparam int unsigned OFF_MASK  = 5;
  localparam int unsigned OFF_BGLD  = 6;

  // control byte field positions (decoded by the datapath strobes)
  localparam int unsigned CB_ONESHOT  = 0;
  localparam int unsigned CB_WIDE     = 1;
  localparam int unsigned CB_PRESC_LO = 2;
  localparam int unsigned CB_IE       = 5;
  localparam int unsigned CB_PERIODIC = 6;
  localparam int unsigned CB_RUN      = 7;
  localparam int unsigned CTRL_W      = 8;

  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_ONESHOT  = 2'd2
  } runMode_e;

  // strobes from register control to the counting datapath
  typedef struct packed {
    logic     loadNow;
    logic     prescClr;
    logic     enable;
    logic     wide;
    runMode_e mode;
    logic [1:0] prescSel;
  } tmrCmd_t;

endpackage

// File: rtl/down_timer_ctrl.sv
module down_timer_ctrl
  import down_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter logic [7:0] CTRL_RST = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] curVal,
  input  logic              expire,
  output tmrCmd_t           cmd,
  output logic [DATA_W-1:0] limitNext,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);

  localparam int PAD_CTRL = DATA_W - CTRL_W;

  logic [CTRL_W-1:0] ctrlReg;
  logic [DATA_W-1:0] limitReg;
  logic              rawFlag;
  logic              wrLoad, wrCtrl, wrClr, wrBg;
  logic              maskedFlag;
  logic [DATA_W-1:0] rdMux;

  assign wrLoad = wrEn && (addr == ADDR_W'(OFF_LOAD));
  assign wrCtrl = wrEn && (addr == ADDR_W'(OFF_CTRL));
  assign wrClr  = wrEn && (addr == ADDR_W'(OFF_CLR));
  assign wrBg   = wrEn && (addr == ADDR_W'(OFF_BGLD));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= CTRL_RST;
      limitReg <= '0;
      rawFlag  <= 1'b0;
    end else begin
      if (wrCtrl) ctrlReg <= wrData[CTRL_W-1:0];
      if (wrLoad || wrBg) limitReg <= wrData;
      if (expire) rawFlag <= 1'b1;
      else if (wrClr) rawFlag <= 1'b0;
    end
  end

  // the value a reload uses this cycle: a fresh load write wins
  assign limitNext = wrLoad ? wrData : limitReg;

  always_comb begin
    cmd.loadNow  = wrLoad;
    cmd.prescClr = wrCtrl;
    cmd.enable   = ctrlReg[CB_RUN];
    cmd.wide     = ctrlReg[CB_WIDE];
    cmd.prescSel = ctrlReg[CB_PRESC_LO +: 2];
    if (ctrlReg[CB_ONESHOT])       cmd.mode = MODE_ONESHOT;
    else if (ctrlReg[CB_PERIODIC]) cmd.mode = MODE_PERIODIC;
    else                           cmd.mode = MODE_FREE;
  end

  assign maskedFlag = rawFlag && ctrlReg[CB_IE];
  assign irqOut     = maskedFlag;

  always_comb begin
    rdMux = '0;
    case (addr)
      ADDR_W'(OFF_LOAD),
      ADDR_W'(OFF_BGLD):  rdMux = limitReg;
      ADDR_W'(OFF_VALUE): rdMux = curVal;
      ADDR_W'(OFF_CTRL):  rdMux = {{PAD_CTRL{1'b0}}, ctrlReg};
      ADDR_W'(OFF_RAW):   rdMux = {{(DATA_W-1){1'b0}}, rawFlag};
      ADDR_W'(OFF_MASK):  rdMux = {{(DATA_W-1){1'b0}}, maskedFlag};
      default:            rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (rdEn) rdData <= rdMux;
  end

  AST_EXPIRE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> rawFlag); // R7
  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (wrClr && !expire) |=> !rawFlag); // R7
  AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrLoad || wrBg) |=> $stable(limitReg)); // R9
  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !wrCtrl |=> $stable(ctrlReg)); // R12
  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R11

endmodule

// File: rtl/down_timer_dp.sv
module down_timer_dp
  import down_timer_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NARROW_W  = 16,
  parameter int PRESC_W   = 8,
  parameter int MID_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  tmrCmd_t           cmd,
  input  logic [DATA_W-1:0] limitNext,
  output logic [DATA_W-1:0] curVal,
  output logic              expire
);

  localparam logic [DATA_W-1:0]  NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [PRESC_W-1:0] MID_TOP     = PRESC_W'((1 << MID_SHIFT) - 1);
  localparam logic [PRESC_W-1:0] FULL_TOP    = {PRESC_W{1'b1}};

  logic [PRESC_W-1:0] prescCnt;
  logic [PRESC_W-1:0] prescTop;
  logic               step;
  logic [DATA_W-1:0]  cntReg;
  logic [DATA_W-1:0]  widthMask;
  logic [DATA_W-1:0]  maskedCnt;
  logic [DATA_W-1:0]  reloadVal;
  logic               atZero;

  always_comb begin
    case (cmd.prescSel)
      2'd1:    prescTop = MID_TOP;
      2'd2:    prescTop = FULL_TOP;
      default: prescTop = '0;
    endcase
  end

  assign step = cmd.enable && tickEn && (prescCnt == prescTop);

  always_ff @(posedge clk) begin
    if (!rstN) prescCnt <= '0;
    else if (cmd.prescClr) prescCnt <= '0;
    else if (cmd.enable && tickEn) prescCnt <= step ? '0 : prescCnt + PRESC_W'(1);
  end

  assign widthMask = cmd.wide ? {DATA_W{1'b1}} : NARROW_MASK;
  assign maskedCnt = cntReg & widthMask;
  assign atZero    = (maskedCnt == '0);
  assign reloadVal = (cmd.mode == MODE_FREE) ? widthMask : (limitNext & widthMask);

  always_ff @(posedge clk) begin
    if (!rstN) cntReg <= '0;
    else if (cmd.loadNow) cntReg <= reloadVal;
    else if (step) begin
      if (!atZero) cntReg <= maskedCnt - DATA_W'(1);
      else if (cmd.mode != MODE_ONESHOT) cntReg <= reloadVal;
    end
  end

  assign curVal = maskedCnt;
  assign expire = step && !cmd.loadNow && (maskedCnt == DATA_W'(1));

  AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    prescCnt <= prescTop); // R2
  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (step && !cmd.loadNow && !atZero) |=> (cntReg == $past(maskedCnt) - DATA_W'(1))); // R5
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (step && !cmd.loadNow && atZero && cmd.mode == MODE_FREE) |=> (cntReg == $past(widthMask))); // R4
  AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.mode == MODE_ONESHOT && atZero && !cmd.loadNow) |=> $stable(cntReg)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.enable && !cmd.loadNow) |=> $stable(cntReg)); // R13

endmodule

// File: rtl/down_timer.sv
module down_timer
  import down_timer_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int NARROW_W  = 16,
  parameter int PRESC_W   = 8,
  parameter int MID_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);

  tmrCmd_t           cmd;
  logic [DATA_W-1:0] limitNext;
  logic [DATA_W-1:0] curVal;
  logic              expire;

  down_timer_ctrl #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .wrEn(wrEn),
    .rdEn(rdEn),
    .addr(addr),
    .wrData(wrData),
    .curVal(curVal),
    .expire(expire),
    .cmd(cmd),
    .limitNext(limitNext),
    .rdData(rdData),
    .irqOut(irqOut)
  );

  down_timer_dp #(
    .DATA_W(DATA_W),
    .NARROW_W(NARROW_W),
    .PRESC_W(PRESC_W),
    .MID_SHIFT(MID_SHIFT)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .tickEn(tickEn),
    .cmd(cmd),
    .limitNext(limitNext),
    .curVal(curVal),
    .expire(expire)
  );

endmodule

// File: tb/down_timer_bench.sv
module down_timer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  down_timer u_down_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    chk(req, rdData, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tickEn = 1'b1;
    end
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // reset state
    rdChk(4'd2, 32'h20, "R1 ctrl");
    rdChk(4'd0, 32'h0, "R1 limit");
    rdChk(4'd1, 32'h0, "R1 value");
    rdChk(4'd4, 32'h0, "R1 raw");
    rdChk(4'd5, 32'h0, "R1 masked");
    chk("R1 irqOut", {31'b0, irqOut}, 32'h0);

    // prescale codes: div 1,16,256,1
    for (int code = 0; code < 4; code++) begin
      int div;
      div = (code == 1) ? 16 : (code == 2) ? 256 : 1;
      wr(4'd2, 32'hE2 | (code << 2));
      wr(4'd0, 32'd1000);
      ticks(3 * div + div - 1);
      rdChk(4'd1, 32'd997, "R2 prescale partial");
      ticks(1);
      rdChk(4'd1, 32'd996, "R2 prescale boundary");
    end

    // prescaler restart on control write
    wr(4'd2, 32'hE6);
    wr(4'd0, 32'd100);
    ticks(10);
    wr(4'd2, 32'hE6);
    ticks(10);
    rdChk(4'd1, 32'd100, "R2 prescaler cleared");
    ticks(6);
    rdChk(4'd1, 32'd99, "R2 prescaler cleared step");
    rdChk(4'd2, 32'hE6, "R3 ctrl readback");

    // periodic sweep over limit and elapsed ticks
    wr(4'd2, 32'hE2);
    for (int lim = 0; lim < 6; lim++) begin
      for (int t = 0; t < 13; t++) begin
        logic [31:0] expRaw;
        wr(4'd0, lim);
        wr(4'd3, 32'h0);
        ticks(t);
        expRaw = (lim > 0 && t >= lim) ? 32'd1 : 32'd0;
        rdChk(4'd1, lim - (t % (lim + 1)), "R5 periodic value");
        rdChk(4'd4, expRaw, "R7 raw after ticks");
        chk("R8 irqOut follows raw", {31'b0, irqOut}, expRaw);
      end
    end

    // one-shot stops at zero
    wr(4'd2, 32'hA3);
    for (int t = 0; t < 9; t++) begin
      wr(4'd0, 32'd4);
      wr(4'd3, 32'h0);
      ticks(t);
      rdChk(4'd1, (t >= 4) ? 32'd0 : 32'd4 - t, "R6 oneshot value");
      rdChk(4'd4, (t >= 4) ? 32'd1 : 32'd0, "R7 oneshot raw");
    end

    // masking (flag currently set)
    wr(4'd2, 32'h83);
    rdChk(4'd4, 32'd1, "R8 raw with ie off");
    rdChk(4'd5, 32'd0, "R8 masked with ie off");
    chk("R8 irqOut with ie off", {31'b0, irqOut}, 32'h0);
    rdChk(4'd2, 32'h83, "R3 ctrl readback 2");
    wr(4'd2, 32'hA3);
    rdChk(4'd5, 32'd1, "R8 masked with ie on");
    chk("R8 irqOut with ie on", {31'b0, irqOut}, 32'h1);
    wr(4'd3, 32'hDEAD);
    rdChk(4'd4, 32'd0, "R7 clear any value");
    chk("R7 irqOut cleared", {31'b0, irqOut}, 32'h0);

    // background load
    wr(4'd2, 32'hE2);
    wr(4'd0, 32'd3);
    wr(4'd6, 32'd10);
    rdChk(4'd1, 32'd3, "R9 background leaves count");
    rdChk(4'd0, 32'd10, "R11 limit at offset 0");
    rdChk(4'd6, 32'd10, "R11 limit at offset 6");
    ticks(3);
    rdChk(4'd1, 32'd0, "R9 count reaches zero");
    ticks(1);
    rdChk(4'd1, 32'd10, "R9 staged limit used");

    // free-running 16-bit
    wr(4'd2, 32'h80);
    wr(4'd0, 32'd5);
    rdChk(4'd1, 32'hFFFF, "R4 free16 loads max");
    rdChk(4'd0, 32'd5, "R4 limit kept");
    ticks(3);
    rdChk(4'd1, 32'hFFFC, "R4 free16 count");
    wr(4'd0, 32'd5);
    wr(4'd3, 32'h0);
    ticks(32'hFFFF);
    rdChk(4'd1, 32'h0, "R4 free16 at zero");
    rdChk(4'd4, 32'd1, "R7 free16 expiry");
    chk("R8 irqOut gated", {31'b0, irqOut}, 32'h0);
    ticks(1);
    rdChk(4'd1, 32'hFFFF, "R4 free16 wrap");

    // free-running 32-bit
    wr(4'd2, 32'h82);
    wr(4'd0, 32'd7);
    rdChk(4'd1, 32'hFFFF_FFFF, "R4 free32 loads max");
    ticks(2);
    rdChk(4'd1, 32'hFFFF_FFFD, "R4 free32 count");

    // narrow periodic
    wr(4'd2, 32'hE0);
    wr(4'd0, 32'h0001_2345);
    wr(4'd3, 32'h0);
    rdChk(4'd1, 32'h2345, "R10 narrow load");
    rdChk(4'd0, 32'h0001_2345, "R10 limit full width");
    ticks(32'h2345);
    rdChk(4'd1, 32'h0, "R10 narrow expiry count");
    rdChk(4'd4, 32'd1, "R10 narrow expiry flag");

    // ignored writes and unmapped reads
    wr(4'd1, 32'hABCD);
    rdChk(4'd1, 32'h0, "R12 value write ignored");
    wr(4'd7, 32'hFFFF_FFFF);
    wr(4'd15, 32'hFFFF_FFFF);
    rdChk(4'd2, 32'hE0, "R12 ctrl untouched");
    rdChk(4'd0, 32'h0001_2345, "R12 limit untouched");
    rdChk(4'd7, 32'h0, "R12 unmapped read 7");
    rdChk(4'd15, 32'h0, "R12 unmapped read 15");
    rdChk(4'd3, 32'h0, "R12 clear reads zero");

    // disabled timer holds
    wr(4'd2, 32'h62);
    wr(4'd0, 32'd20);
    ticks(50);
    rdChk(4'd1, 32'd20, "R13 disabled holds");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(190000 * 5);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule